// File: doc/BRIEF.md
# Multiplexer-Based Programmable Logic Module

This block is a small configurable combinational cell made of three 2:1 multiplexers and one two-input OR gate. Two front multiplexers each choose between two data pins under their own select pin. An output multiplexer then picks one of the two front results. The output multiplexer's select is the OR of two separate select pins. A function is mapped onto the cell by tying each of its eight pins to a logic variable or to a constant.

A wrapper drives the eight pins from a configuration word. For each pin, a 2-bit code picks constant 0, constant 1, variable A or variable B. This makes every two-input Boolean function available from a single cell. A direct mode instead passes eight raw pin values straight through, so that functions of more than two variables can be placed by hand.

A feedback mode routes a stored copy of the cell output back onto the first data pin. With the right configuration this forms a level-sensitive latch with an explicit enable. The stored copy is a clocked register, so the loop stays synthesizable.

Top module: `mlc_top`

## Requirements
- R1: Each front multiplexer outputs its data-0 pin when its select pin is 0 and its data-1 pin when its select pin is 1.
- R2: The output `y` equals the second front multiplexer's output when pin OS0 OR pin OS1 is 1, and the first front multiplexer's output when both are 0.
- R3: Pin i takes its source from `cfg[2i+1:2i]`, coded 00 = constant 0, 01 = constant 1, 10 = `var_a`, 11 = `var_b`. The pin indices are:
  - 0 = F0 data-0
  - 1 = F0 data-1
  - 2 = F0 select
  - 3 = F1 data-0
  - 4 = F1 data-1
  - 5 = F1 select
  - 6 = OS0
  - 7 = OS1
- R4: Each of the sixteen Boolean functions of `var_a` and `var_b` is produced by some configuration word.
- R5: With `use_dir` = 1 (and `fb_en` = 0), pin i equals `pin_dir[i]`, and `cfg`, `var_a` and `var_b` have no effect on `y`.
- R6: In direct mode, the mapping below yields y = A·B + B'·C + D for all sixteen input combinations:
  - OS0 = B and OS1 = 0
  - F1: select A between D and 1
  - F0: select C between D and 1
- R7: A feedback register is cleared to 0 by asynchronous reset. While `fb_en` = 1, it loads `y` on each rising clock edge, and pin 0 is driven by it instead of by `cfg` or `pin_dir`.
- R8: With `fb_en` = 1 and the configuration F0 data-1 = A, F0 select = B (other codes 00), the cell acts as a latch with data `var_a` and gate `var_b`. It is transparent while B = 1 and holds the last value while B = 0.
- R9: While `fb_en` = 0, the feedback register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the feedback register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 16 | Per-pin 2-bit source codes |
| var_a | input | 1 | Logic variable A |
| var_b | input | 1 | Logic variable B |
| use_dir | input | 1 | Select raw pin values instead of coded sources |
| pin_dir | input | 8 | Raw pin values for direct mode |
| fb_en | input | 1 | Feedback mode: pin 0 from stored output, register loads |
| y | output | 1 | Cell output |

## Verification
The main function is tried with a catalogue of sixteen configuration words, one per two-input function. Each word is walked through all four (A, B) pairs. The four-bit truth table tells apart:
- a swapped select sense in a front multiplexer;
- a wrong pin code;
- a swapped output-select path;
- an AND in place of the OR on the output select.

Some catalogue entries use only OS1 and others only OS0, so each half of the OR is exercised alone. The direct mode is swept over all sixteen four-variable combinations while `cfg` and the variables are held at conflicting values. The latch is tried with the following gate and data patterns:
- gate held high;
- gate falling;
- data toggling while the gate is low;
- feedback disabled across several clock edges.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  localparam int PIN_CNT = 8;
  localparam int CODE_W  = 2;
  localparam int CFG_W   = PIN_CNT * CODE_W;

  // Pin positions inside the cell (order fixes the cfg bit layout)
  localparam int PIN_F0_D0  = 0;
  localparam int PIN_F0_D1  = 1;
  localparam int PIN_F0_SEL = 2;
  localparam int PIN_F1_D0  = 3;
  localparam int PIN_F1_D1  = 4;
  localparam int PIN_F1_SEL = 5;
  localparam int PIN_OS0    = 6;
  localparam int PIN_OS1    = 7;

  typedef enum logic [CODE_W-1:0] {
    SRC_ZERO = 2'b00,
    SRC_ONE  = 2'b01,
    SRC_VA   = 2'b10,
    SRC_VB   = 2'b11
  } src_e;

  // 2:1 selection: d0 when s is low, d1 when s is high
  function automatic logic mux_pick(input logic d0, input logic d1, input logic s);
    return (d0 & ~s) | (d1 & s);
  endfunction

  // Pin source decode
  function automatic logic src_value(input logic [CODE_W-1:0] code,
                                     input logic va, input logic vb);
    logic r;
    case (src_e'(code))
      SRC_ZERO: r = 1'b0;
      SRC_ONE:  r = 1'b1;
      SRC_VA:   r = va;
      default:  r = vb;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mlc_mux2.sv
module mlc_mux2 import mlc_pkg::*; (
  input  logic d0,
  input  logic d1,
  input  logic s,
  output logic y
);
  assign y = mux_pick(d0, d1, s);
endmodule

// File: rtl/mlc_pin_src.sv
module mlc_pin_src import mlc_pkg::*; #(
  parameter bit HAS_FB = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  input  logic              va,
  input  logic              vb,
  input  logic              use_dir,
  input  logic              dir_val,
  input  logic              fb_en,
  input  logic              fb_val,
  output logic              pin
);
  logic coded;
  logic base;

  assign coded = src_value(code, va, vb);
  assign base  = use_dir ? dir_val : coded;

  generate
    if (HAS_FB) begin : g_fb
      assign pin = fb_en ? fb_val : base;
    end else begin : g_nofb
      logic unused_fb;
      assign unused_fb = fb_en ^ fb_val;
      assign pin = base;
    end
  endgenerate
endmodule

// File: rtl/mlc_core.sv
module mlc_core import mlc_pkg::*; (
  input  logic [PIN_CNT-1:0] pins,
  output logic               f0_out,
  output logic               f1_out,
  output logic               y
);
  logic out_sel;

  mlc_mux2 u_front0 (
    .d0(pins[PIN_F0_D0]), .d1(pins[PIN_F0_D1]), .s(pins[PIN_F0_SEL]), .y(f0_out)
  );

  mlc_mux2 u_front1 (
    .d0(pins[PIN_F1_D0]), .d1(pins[PIN_F1_D1]), .s(pins[PIN_F1_SEL]), .y(f1_out)
  );

  assign out_sel = pins[PIN_OS0] | pins[PIN_OS1];

  mlc_mux2 u_outmux (
    .d0(f0_out), .d1(f1_out), .s(out_sel), .y(y)
  );
endmodule

// File: rtl/mlc_top.sv
module mlc_top import mlc_pkg::*; #(
  parameter int FB_PIN = PIN_F0_D0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             var_a,
  input  logic             var_b,
  input  logic             use_dir,
  input  logic [PIN_CNT-1:0] pin_dir,
  input  logic             fb_en,
  output logic             y
);
  logic [PIN_CNT-1:0] pin_w;
  logic               f0_w;
  logic               f1_w;
  logic               y_w;
  logic               fb_q;

  generate
    for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
      mlc_pin_src #(.HAS_FB(i == FB_PIN)) u_src (
        .code    (cfg[i*CODE_W +: CODE_W]),
        .va      (var_a),
        .vb      (var_b),
        .use_dir (use_dir),
        .dir_val (pin_dir[i]),
        .fb_en   (fb_en),
        .fb_val  (fb_q),
        .pin     (pin_w[i])
      );
    end
  endgenerate

  mlc_core u_core (
    .pins   (pin_w),
    .f0_out (f0_w),
    .f1_out (f1_w),
    .y      (y_w)
  );

  // Stored copy of the output that closes the feedback loop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fb_q <= 1'b0;
    else if (fb_en) fb_q <= y_w;
  end

  assign y = y_w;
endmodule

// File: rtl/mlc_chk.sv
module mlc_chk import mlc_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input logic [CFG_W-1:0]   cfg,
  input logic               use_dir,
  input logic [PIN_CNT-1:0] pin_dir,
  input logic               fb_en,
  input logic               y,
  input logic [PIN_CNT-1:0] pins,
  input logic               f0_out,
  input logic               f1_out,
  input logic               fb_q
);

  p_front_mux_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pins[PIN_F1_SEL] |-> (f1_out == pins[PIN_F1_D1]));

  p_out_front0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pins[PIN_OS0] || pins[PIN_OS1]) |-> (y == f0_out));

  p_out_front1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pins[PIN_OS0] || pins[PIN_OS1]) |-> (y == f1_out));

  p_code_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_dir && cfg[PIN_OS0*CODE_W +: CODE_W] == 2'b00) |-> !pins[PIN_OS0]);

  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (use_dir && !fb_en) |-> (pins == pin_dir));

  p_fb_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fb_en |=> (fb_q == $past(y)));

  p_fb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_en |=> $stable(fb_q));

endmodule

bind mlc_top mlc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg     (cfg),
  .use_dir (use_dir),
  .pin_dir (pin_dir),
  .fb_en   (fb_en),
  .y       (y),
  .pins    (pin_w),
  .f0_out  (f0_w),
  .f1_out  (f1_w),
  .fb_q    (fb_q)
);

// File: tb/sim_mlc_top.sv
`timescale 1ns/1ps
module sim_mlc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg = '0;
  logic        var_a = 1'b0;
  logic        var_b = 1'b0;
  logic        use_dir = 1'b0;
  logic [7:0]  pin_dir = '0;
  logic        fb_en = 1'b0;
  logic        y;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mlc_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .var_a(var_a), .var_b(var_b),
    .use_dir(use_dir), .pin_dir(pin_dir), .fb_en(fb_en), .y(y)
  );

  localparam logic [1:0] CZ = 2'b00, C1 = 2'b01, CA = 2'b10, CB = 2'b11;

  // {truth[3:0] indexed by {a,b}, os1, os0, f1s, f1d1, f1d0, f0s, f0d1, f0d0}
  localparam logic [19:0] VEC [16] = '{
    {4'b0000, CZ, CZ, CZ, CZ, CZ, CZ, CZ, CZ},   // const 0
    {4'b1000, CZ, CZ, CZ, CZ, CZ, CA, CB, CZ},   // A and B
    {4'b0100, CZ, CZ, CZ, CZ, CZ, CB, CZ, CA},   // A and not B
    {4'b1100, CZ, CZ, CZ, CZ, CZ, CZ, CZ, CA},   // A
    {4'b0010, CZ, CZ, CZ, CZ, CZ, CA, CZ, CB},   // not A and B
    {4'b1010, C1, CZ, CZ, CZ, CB, CZ, CZ, CZ},   // B through second front mux
    {4'b0110, CZ, CA, CB, CZ, C1, CZ, CZ, CB},   // xor
    {4'b1110, CZ, CZ, CZ, CZ, CZ, CA, C1, CB},   // or
    {4'b0001, CA, CZ, CZ, CZ, CZ, CB, CZ, C1},   // nor, select on OS1
    {4'b1001, CZ, CA, CZ, CZ, CB, CB, CZ, C1},   // xnor
    {4'b0101, CZ, CZ, CZ, CZ, CZ, CB, CZ, C1},   // not B
    {4'b1101, CZ, CZ, CZ, CZ, CZ, CB, CA, C1},   // A or not B
    {4'b0011, CZ, CZ, CZ, CZ, CZ, CA, CZ, C1},   // not A
    {4'b1011, CZ, CZ, CZ, CZ, CZ, CA, CB, C1},   // not A or B
    {4'b0111, CZ, CA, CB, CZ, C1, CZ, CZ, C1},   // nand
    {4'b1111, C1, C1, CZ, CZ, C1, CZ, CZ, CZ}    // const 1, both selects high
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    // Reset state: R7 register cleared, all-zero config gives 0
    fb_en = 1'b1;
    #23;
    chk("R7 reset output", y, 1'b0);
    @(negedge clk);
    fb_en = 1'b0;
    rst_n = 1'b1;
    #1 chk("R3 zero config", y, 1'b0);

    // R1 R2 R3 R4: function catalogue
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        cfg   = VEC[i][15:0];
        var_a = k[1];
        var_b = k[0];
        #1 chk($sformatf("R1 R2 R3 R4 fn%0d ab=%0d", i, k), y, VEC[i][16 + k]);
      end
    end

    // R5 R6: direct mode with conflicting cfg and variables
    for (int v = 0; v < 16; v++) begin
      logic a, b, c, d, exp;
      a = v[3]; b = v[2]; c = v[1]; d = v[0];
      exp = (a & b) | (~b & c) | d;
      @(negedge clk);
      use_dir = 1'b1;
      cfg     = {8{CB}};
      var_a   = ~var_a;
      var_b   = v[0];
      pin_dir = {1'b0, b, a, 1'b1, d, c, 1'b1, d};
      #1 chk($sformatf("R5 R6 abcd=%0d", v), y, exp);
    end
    @(negedge clk);
    use_dir = 1'b0;

    // R8: latch, data = var_a, gate = var_b
    cfg   = {CZ, CZ, CZ, CZ, CZ, CB, CA, CZ};
    fb_en = 1'b1; var_a = 1'b1; var_b = 1'b1;
    #1 chk("R8 transparent high", y, 1'b1);
    @(negedge clk);
    var_b = 1'b0; var_a = 1'b0;
    #1 chk("R8 hold after gate low", y, 1'b1);
    @(negedge clk);
    var_a = 1'b1;
    #1 chk("R8 hold data up", y, 1'b1);
    @(negedge clk);
    var_a = 1'b0;
    #1 chk("R8 hold data down", y, 1'b1);
    @(negedge clk);
    var_b = 1'b1;
    #1 chk("R8 transparent low", y, 1'b0);
    @(negedge clk);
    var_b = 1'b0; var_a = 1'b1;
    #1 chk("R8 hold zero", y, 1'b0);

    // R9: register frozen while feedback is off
    @(negedge clk);
    fb_en = 1'b0; var_b = 1'b1; var_a = 1'b1;
    #1 chk("R9 open path", y, 1'b1);
    repeat (3) @(negedge clk);
    fb_en = 1'b1; var_b = 1'b0;
    #1 chk("R9 stored value kept", y, 1'b0);

    // R7: load a one, then asynchronous reset clears it
    @(negedge clk);
    var_b = 1'b1; var_a = 1'b1;
    @(negedge clk);
    var_b = 1'b0;
    #1 chk("R7 loaded value", y, 1'b1);
    rst_n = 1'b0;
    #1 chk("R7 async clear", y, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    summary();
    $finish;
  end

endmodule